// File: doc/BRIEF.md
# Lockable Cache Way Victim Selector

This block picks the way that receives a new line on a fill in a four-way set-associative data cache. Software can bar any way from allocation. A lock mask register holds one bit per way. Software reads and writes it through a small configuration port. Each allocation request gets its victim in the same cycle, as a way index and as a one-hot mask. A round-robin pointer drives the choice and steps past barred ways.

The block counts line fills that have been started and not yet finished. A configuration write is not accepted while that count is above zero. It is also not accepted in a cycle in which a new fill is being accepted. The requester keeps the write valid until the ready signal rises, so the mask never changes under a fill that is in progress. Locking applies only to choosing a victim. Lookups that hit in a barred way are not affected.

Top module: `lockable_victim_sel`

## Requirements
- R1: The register reads back the lock mask in bits [3:0], with bit i barring way i, and all higher bits read as zero whatever value was written to them.
- R2: After reset the mask is all zero, the pointer is at way 0, and `cfg_wr_ready` is high, so the first victim is way 0.
- R3: While at least one lock bit is clear, the victim is never a way whose lock bit is set.
- R4: The victim is the first unbarred way found by searching upward from the pointer and wrapping from way 3 to way 0. The pointer's own way counts as the start of the search.
- R5: When all four lock bits are set, way 0 is treated as unbarred and becomes the victim.
- R6: `cfg_wr_ready` is low whenever fills are outstanding or an allocation is accepted in the same cycle. A write offered while ready is low leaves the mask unchanged.
- R7: A write that is held valid through a stall takes effect at the end of the first cycle in which the outstanding count is zero and no allocation is being accepted.
- R8: The outstanding count rises by one for each accepted allocation and falls by one for each `fill_done` pulse. Ready returns only when the count reaches zero.
- R9: The pointer moves only when an allocation is accepted, and then moves to the way above the victim, modulo 4. A request that is not accepted leaves the next victim unchanged.
- R10: `victim_onehot` has exactly the bit numbered `victim_idx` set, in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_valid | input | 1 | Configuration write request |
| cfg_wr_data | input | REG_W | Write data; only bits [3:0] are used |
| cfg_wr_ready | output | 1 | Write is accepted at this edge when high |
| cfg_rd_data | output | REG_W | Current lock mask, zero-extended |
| alloc_req | input | 1 | Victim requested this cycle |
| alloc_accept | input | 1 | The requested allocation proceeds and starts a fill |
| victim_idx | output | 2 | Chosen way, encoded |
| victim_onehot | output | 4 | Chosen way, one-hot |
| fill_done | input | 1 | One outstanding fill has completed |

## Verification
Assertions check four rules on every cycle: the victim is never a barred way, all-barred falls back to way 0, the victim mask is one-hot, and the mask and pointer stay still when they are not allowed to move. The counter also guards against overflow and underflow. The bench's scenarios are needed to show the exact search order and wrap, the moment a stalled write lands, and the read-back of upper bits as zero. A behavioural model compares every output on every clock, including under random traffic.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
    localparam int WAYS  = 4;
    localparam int IDX_W = $clog2(WAYS);

    typedef logic [WAYS-1:0]  way_mask_t;
    typedef logic [IDX_W-1:0] way_idx_t;

    typedef struct packed {
        way_mask_t lock;
        way_idx_t  ptr;
    } sel_state_t;
endpackage

// File: rtl/vsel_pick.sv
module vsel_pick
    import vsel_pkg::*;
(
    input  way_mask_t lock_i,
    input  way_idx_t  ptr_i,
    output way_idx_t  idx_o,
    output way_mask_t onehot_o
);
    way_mask_t avail;

    // all barred: way 0 is released
    always_comb begin
        if (&lock_i) avail = way_mask_t'(1);
        else         avail = ~lock_i;
    end

    // search upward from ptr; lowest offset wins (WAYS is a power of two)
    always_comb begin
        idx_o = ptr_i;
        for (int k = WAYS - 1; k >= 0; k--) begin
            way_idx_t w;
            w = ptr_i + way_idx_t'(k);
            if (avail[w]) idx_o = w;
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_dec
        assign onehot_o[g] = (idx_o == way_idx_t'(g));
    end
endmodule

// File: rtl/vsel_fill_ctr.sv
module vsel_fill_ctr #(
    parameter int MAX_FILLS = 8,
    localparam int CW = $clog2(MAX_FILLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic          idle_o,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && !dec_i)      cnt_d = cnt_q + CW'(1);
        else if (dec_i && !inc_i) cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idle_o = (cnt_q == '0);
    assign cnt_o  = cnt_q;

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i) |-> (cnt_q != CW'(MAX_FILLS)));
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i) |-> (cnt_q != '0));
endmodule

// File: rtl/lockable_victim_sel.sv
module lockable_victim_sel
    import vsel_pkg::*;
#(
    parameter int MAX_FILLS = 8,
    parameter int REG_W     = 32,
    localparam int CW = $clog2(MAX_FILLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_valid,
    input  logic [REG_W-1:0] cfg_wr_data,
    output logic             cfg_wr_ready,
    output logic [REG_W-1:0] cfg_rd_data,
    input  logic             alloc_req,
    input  logic             alloc_accept,
    output logic [IDX_W-1:0] victim_idx,
    output logic [WAYS-1:0]  victim_onehot,
    input  logic             fill_done
);
    sel_state_t    st_d, st_q;
    logic          take;
    logic          fill_idle;
    logic [CW-1:0] fill_cnt;
    way_idx_t      pick_idx;
    way_mask_t     pick_oh;

    assign take = alloc_req & alloc_accept;

    vsel_fill_ctr #(.MAX_FILLS(MAX_FILLS)) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (take),
        .dec_i  (fill_done),
        .idle_o (fill_idle),
        .cnt_o  (fill_cnt)
    );

    vsel_pick u_pick (
        .lock_i   (st_q.lock),
        .ptr_i    (st_q.ptr),
        .idx_o    (pick_idx),
        .onehot_o (pick_oh)
    );

    // writes wait for drained fills and for no fill starting now
    assign cfg_wr_ready = fill_idle & ~take;

    always_comb begin
        st_d = st_q;
        if (cfg_wr_valid && cfg_wr_ready) st_d.lock = cfg_wr_data[WAYS-1:0];
        if (take)                         st_d.ptr  = pick_idx + way_idx_t'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_rd_data   = {{(REG_W - WAYS){1'b0}}, st_q.lock};
    assign victim_idx    = pick_idx;
    assign victim_onehot = pick_oh;

    p_victim_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !(&st_q.lock)) |-> ((victim_onehot & st_q.lock) == '0));
    p_all_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && (&st_q.lock)) |-> (victim_idx == '0));
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> ($countones(victim_onehot) == 1));
    p_write_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt != '0) |=> $stable(st_q.lock));
    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(st_q.ptr));
endmodule

// File: tb/sim_lockable_victim_sel.sv
`timescale 1ns/1ps
module sim_lockable_victim_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_valid = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        cfg_wr_ready;
    logic [31:0] cfg_rd_data;
    logic        alloc_req = 1'b0;
    logic        alloc_accept = 1'b0;
    logic [1:0]  victim_idx;
    logic [3:0]  victim_onehot;
    logic        fill_done = 1'b0;

    int total = 0;
    int bad = 0;
    int m_lock = 0;
    int m_ptr = 0;
    int m_cnt = 0;
    bit m_applied = 0;

    always #10 clk = ~clk;

    lockable_victim_sel u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_valid(cfg_wr_valid), .cfg_wr_data(cfg_wr_data),
        .cfg_wr_ready(cfg_wr_ready), .cfg_rd_data(cfg_rd_data),
        .alloc_req(alloc_req), .alloc_accept(alloc_accept),
        .victim_idx(victim_idx), .victim_onehot(victim_onehot),
        .fill_done(fill_done)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_victim(int lk, int p);
        int av;
        av = (lk == 15) ? 1 : (~lk & 15);
        for (int k = 0; k < 4; k++) begin
            if (((av >> ((p + k) % 4)) & 1) == 1) return (p + k) % 4;
        end
        return 0;
    endfunction

    // one clock: drive at negedge, compare, advance model, wait for next negedge
    task automatic cyc(input bit wv, input int wd, input bit rq, input bit ac, input bit dn, input string vtag);
        bit take, rdy;
        int v;
        cfg_wr_valid = wv; cfg_wr_data = wd; alloc_req = rq; alloc_accept = ac; fill_done = dn;
        #2;
        take = rq && ac;
        rdy = (m_cnt == 0) && !take;
        check(cfg_wr_ready == rdy, (m_cnt != 0) ? "R8 ready" : "R6 ready", cfg_wr_ready, rdy);
        check(cfg_rd_data == 32'(m_lock), "R1 readback", cfg_rd_data, m_lock);
        v = exp_victim(m_lock, m_ptr);
        if (rq) begin
            check(victim_idx == 2'(v), (m_lock == 15) ? "R5 victim" : vtag, victim_idx, v);
            check(victim_onehot == 4'(1 << victim_idx), "R10 onehot", victim_onehot, 1 << victim_idx);
            if (m_lock != 15)
                check((victim_onehot & 4'(m_lock)) == 0, "R3 barred", victim_onehot, 0);
        end
        m_applied = wv && rdy;
        if (m_applied) m_lock = wd & 15;
        if (take) m_ptr = (v + 1) % 4;
        m_cnt = m_cnt + int'(take) - int'(dn);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain();
        while (m_cnt > 0) cyc(0, 0, 0, 0, 1, "R8");
    endtask

    task automatic write_now(input int d);
        drain();
        cyc(1, d, 0, 0, 0, "R6");
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(cfg_rd_data == 0, "R2 reset mask", cfg_rd_data, 0);
        check(cfg_wr_ready == 1'b1, "R2 reset ready", cfg_wr_ready, 1);
        alloc_req = 1'b1; #1;
        check(victim_idx == 0, "R2 first victim", victim_idx, 0);
        alloc_req = 1'b0;
        @(negedge clk);

        // round robin with every way free
        cyc(0, 0, 1, 1, 0, "R4");
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, 1, "R4");
        drain();

        // bar ways 0 and 2
        write_now(32'h5);
        check(cfg_rd_data == 32'h5, "R1 write", cfg_rd_data, 5);
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 0, "R4");
        // requests not accepted must leave the pointer alone
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0, "R9");
        drain();
        cyc(0, 0, 1, 0, 0, "R9");

        // stalled write while two fills are outstanding
        write_now(32'h0);
        cyc(0, 0, 1, 1, 0, "R4");
        cyc(0, 0, 1, 1, 0, "R4");
        check(m_cnt == 2, "R8 model count", m_cnt, 2);
        cyc(1, 32'hE, 0, 0, 0, "R6");
        check(cfg_rd_data == 0, "R6 write ignored while busy", cfg_rd_data, 0);
        m_applied = 0;
        while (!m_applied) cyc(1, 32'hE, 0, 0, m_cnt != 0, "R7");
        check(cfg_rd_data == 32'hE, "R7 held write landed", cfg_rd_data, 32'hE);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 1, "R4");
        drain();

        // upper bits discarded, all ways barred
        write_now(32'hFFFF_FFFF);
        check(cfg_rd_data == 32'hF, "R1 upper bits zero", cfg_rd_data, 32'hF);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 1, "R5");
        drain();

        // write in the same cycle as an accepted allocation
        write_now(32'h3);
        cyc(1, 32'h8, 1, 1, 0, "R6");
        check(cfg_rd_data == 32'h3, "R6 write lost to fill start", cfg_rd_data, 3);
        drain();

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            cyc(r[0], r[11:8], r[1], r[2] && (m_cnt < 7), r[3] && (m_cnt > 0), "R4");
        end
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule